// File: doc/BRIEF.md
# Dual Down-Counter Timer with Identification Space

The block holds two independent down-counting timers in one 4 KB register space. Each timer gets its tick from a clock-enable divider on the bus clock, and the two dividers have separate rates. A simple synchronous bus selects a timer by address. Each timer can run in one of three ways:

- free-running, wrapping to all ones;
- periodic, reloading from a load register;
- one-shot, stopping itself at zero.

Each timer can count over 16 or 32 bits. A prescaler divides the tick by 1, 16 or 256.

The two timer interrupts are ORed into a single line. The top 32 bytes of the space return fixed identification bytes. The two integration-test offsets decode, but they read zero and do nothing. Every other offset outside the timer windows reads zero, and writes there are dropped.

Reads are combinational: `rdata` reflects `addr` in the same cycle that `sel` is high and `wr` is low, and is zero otherwise. Writes take effect at the clock edge on which `sel` and `wr` are both high. Address bits [1:0] are ignored.

Top module: `dual_timer`

## Requirements
- R1: Byte offsets 0x00-0x1F address timer 0 and 0x20-0x3F address timer 1. Within a window, the word index addr[4:2] selects the register:
  - 0: control, read/write;
  - 1: load, where a write also loads the count;
  - 2: background load;
  - 3: current count, read-only;
  - 4: raw flag;
  - 5: flag ANDed with the interrupt enable;
  - 6: flag clear, write-only, reads zero;
  - 7: reads zero.
- R2: Offsets 0xFE0-0xFFC return, one per word, the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rdata[7:0], with rdata[31:8] zero.
- R3: `irq` is high exactly when, for either timer, the raw flag is set and control bit 6 (interrupt enable) is set.
- R4: Offsets 0xF00 and 0xF04 read zero, and writes to them change no state.
- R5: Writes at offsets 0x40 and above are ignored. Reads of any offset not covered by R1, R2 or R4 return zero.
- R6: Timer 0 receives a base tick every RATE0 clocks and timer 1 every RATE1 clocks. Control bits [5:4] further divide the tick: 0 = /1, 1 = /16, 2 = /256, 3 = /1.
- R7: On each divided tick while control bit 0 (enable) is set, a nonzero count decrements by one. A count of zero instead sets the raw flag and reloads.
- R8: The reload source depends on control bits 1 (one-shot) and 2 (periodic):
  - both clear: the counter reloads to all ones (free-running);
  - periodic set and one-shot clear: the counter reloads from the load register;
  - one-shot set: the count stays at zero and hardware clears the enable bit.
- R9: With control bit 3 clear (16-bit mode), the count reads, and is tested for zero, on its low 16 bits only. Bit 3 set selects the full 32 bits.
- R10: Writing load sets both the load register and the count. Writing background load sets only the load register.
- R11: A write to the clear word clears the raw flag. An expiry in the same cycle wins and leaves the flag set.
- R12: After reset:
  - control is 0x40 (interrupt enable only);
  - load is 0;
  - the count is all ones;
  - both raw flags are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the 4 KB space |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not reading |
| irq | output | 1 | Merged timer interrupt |

## Verification
The assertions assume that `sel`, `wr` and `addr` are stable across each clock edge. They also assume that no write collides with the reset release. The bench meets both conditions by changing every input only on the falling edge, holding reset for several cycles, and issuing each access for exactly one cycle with idle cycles around it. The stray-write property additionally assumes that nothing else writes the load or configuration bits in the cycle after a write outside the windows. That holds because there is a single bus master and accesses are one cycle apart.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int RATE0 = 4,
  parameter int RATE1 = 4,
  parameter int DW    = 32,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [11:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int NT = 2;

  logic [NT-1:0][CW-1:0] ctrl_v;
  logic [NT-1:0][DW-1:0] load_v;
  logic [NT-1:0][DW-1:0] trd;
  logic [NT-1:0]         raw_v;
  logic [NT-1:0]         ie_v;

  wire we = sel & wr;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam int RATE = (g == 0) ? RATE0 : RATE1;
    localparam int RW   = (RATE > 1) ? $clog2(RATE) : 1;

    logic [RW-1:0] rc;
    logic [7:0]    pre;
    logic [CW-1:0] ctrl;
    logic [DW-1:0] load, cnt;
    logic          raw;

    wire           base   = (rc == RW'(RATE - 1));
    wire [1:0]     div    = ctrl[5:4];
    wire           tick   = base & ((div == 2'd1) ? (pre[3:0] == 4'hF) :
                                    (div == 2'd2) ? (pre == 8'hFF) : 1'b1);
    wire [DW-1:0]  mask   = ctrl[3] ? {DW{1'b1}} : DW'(16'hFFFF);
    wire           run    = ctrl[0] & tick;
    wire           expire = run & ((cnt & mask) == '0);
    wire [DW-1:0]  reload = (ctrl[1] | ctrl[2]) ? load : {DW{1'b1}};
    wire           hit    = we & (addr[11:5] == 7'(g));
    wire [2:0]     w      = addr[4:2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rc   <= '0;
        pre  <= '0;
        ctrl <= CW'(7'h40);
        load <= '0;
        cnt  <= '1;
        raw  <= 1'b0;
      end else begin
        rc <= base ? '0 : rc + 1'b1;
        if (base) pre <= pre + 8'd1;
        if (hit && w == 3'd0)                  ctrl    <= wdata[CW-1:0];
        else if (expire && ctrl[1])            ctrl[0] <= 1'b0;
        if (hit && (w == 3'd1 || w == 3'd2))   load    <= wdata;
        if (hit && w == 3'd1)                  cnt     <= wdata;
        else if (expire) begin
          if (!ctrl[1]) cnt <= reload;
        end else if (run)                      cnt     <= cnt - 1'b1;
        if (expire)                            raw     <= 1'b1;
        else if (hit && w == 3'd6)             raw     <= 1'b0;
      end
    end

    always_comb begin
      case (w)
        3'd0:    trd[g] = DW'(ctrl);
        3'd1:    trd[g] = load;
        3'd2:    trd[g] = load;
        3'd3:    trd[g] = cnt & mask;
        3'd4:    trd[g] = DW'(raw);
        3'd5:    trd[g] = DW'(raw & ctrl[6]);
        default: trd[g] = '0;
      endcase
    end

    assign ctrl_v[g] = ctrl;
    assign load_v[g] = load;
    assign raw_v[g]  = raw;
    assign ie_v[g]   = ctrl[6];
  end

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: return 8'h04;
      3'd1: return 8'h18;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      if (addr[11:6] == 6'd0)        rdata = trd[addr[5]];
      else if (addr[11:5] == 7'h7F)  rdata = DW'(id_byte(addr[4:2]));
    end
  end

  assign irq = |(raw_v & ie_v);
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic [11:0] addr,
  input logic [31:0] rdata,
  input logic        irq,
  input logic [1:0]  raw_v,
  input logic [1:0]  ie_v,
  input logic [13:0] ctrl_v,
  input logic [63:0] load_v
);
  p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(raw_v & ie_v));

  p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_v & ie_v)) |-> irq);

  p_id_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr[11:5] == 7'h7F) |-> (rdata[31:8] == 24'h0));

  p_test_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && (addr[11:2] == 10'h3C0 || addr[11:2] == 10'h3C1)) |-> (rdata == 32'h0));

  p_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr[11:6] != 6'd0) |=>
      ($stable(load_v) && $stable({ctrl_v[13:8], ctrl_v[6:1]})));
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
  .rdata(rdata), .irq(irq), .raw_v(raw_v), .ie_v(ie_v),
  .ctrl_v(ctrl_v), .load_v(load_v)
);

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  string cur_tag = "R12";

  always #4 clk = ~clk;

  dual_timer #(.RATE0(2), .RATE1(3)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int        rate[2] = '{2, 3};
  bit [6:0]  m_ctrl[2];
  bit [31:0] m_load[2], m_cnt[2];
  bit        m_raw[2];
  int        m_rc[2];
  bit [7:0]  m_pre[2];
  bit [7:0]  ids[8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic mreset();
    for (int t = 0; t < 2; t++) begin
      m_ctrl[t] = 7'h40; m_load[t] = 0; m_cnt[t] = 32'hFFFF_FFFF;
      m_raw[t] = 0; m_rc[t] = 0; m_pre[t] = 0;
    end
  endtask

  function automatic bit [31:0] msk(int t);
    return m_ctrl[t][3] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  task automatic mstep();
    for (int t = 0; t < 2; t++) begin
      bit base, tick, expire, hit;
      bit [6:0] nc; bit [31:0] nl, nn; bit nr;
      int d;
      base = (m_rc[t] == rate[t] - 1);
      d = m_ctrl[t][5:4];
      tick = base && (d == 1 ? m_pre[t][3:0] == 4'hF : d == 2 ? m_pre[t] == 8'hFF : 1'b1);
      expire = m_ctrl[t][0] && tick && ((m_cnt[t] & msk(t)) == 0);
      nc = m_ctrl[t]; nl = m_load[t]; nn = m_cnt[t]; nr = m_raw[t];
      if (expire) begin
        nr = 1;
        if (m_ctrl[t][1]) nc[0] = 0;
        else nn = (m_ctrl[t][2]) ? m_load[t] : 32'hFFFF_FFFF;
      end else if (m_ctrl[t][0] && tick) nn = m_cnt[t] - 1;
      hit = sel && wr && (addr[11:5] == 7'(t));
      if (hit) begin
        case (addr[4:2])
          3'd0: nc = wdata[6:0];
          3'd1: begin nl = wdata; nn = wdata; end
          3'd2: nl = wdata;
          3'd6: if (!expire) nr = 0;
          default: ;
        endcase
      end
      m_rc[t] = base ? 0 : m_rc[t] + 1;
      if (base) m_pre[t] = m_pre[t] + 1;
      m_ctrl[t] = nc; m_load[t] = nl; m_cnt[t] = nn; m_raw[t] = nr;
    end
  endtask

  initial mreset();
  always @(posedge clk) if (!rst_n) mreset(); else mstep();

  function automatic bit [31:0] exp_rd(bit [11:0] a);
    int t;
    if (a[11:6] == 0) begin
      t = a[5];
      case (a[4:2])
        3'd0: return {25'h0, m_ctrl[t]};
        3'd1, 3'd2: return m_load[t];
        3'd3: return m_cnt[t] & msk(t);
        3'd4: return {31'h0, m_raw[t]};
        3'd5: return {31'h0, m_raw[t] & m_ctrl[t][6]};
        default: return 0;
      endcase
    end
    if (a[11:5] == 7'h7F) return {24'h0, ids[a[4:2]]};
    return 0;
  endfunction

  task automatic chk(bit [31:0] act, bit [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk({31'h0, irq}, {31'h0, (m_raw[0] & m_ctrl[0][6]) | (m_raw[1] & m_ctrl[1][6])}, "R3");
      if (sel && !wr) chk(rdata, exp_rd(addr), cur_tag);
      else if (!sel) chk(rdata, 32'h0, "R5");
    end
  end

  task automatic acc(bit w, bit [11:0] a, bit [31:0] d, string tag);
    @(negedge clk);
    sel = 1; wr = w; addr = a; wdata = d; cur_tag = tag;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic rdall(string tag);
    for (int a = 0; a < 64; a += 4) acc(0, 12'(a), 0, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    rdall("R12");
    for (int i = 0; i < 8; i++) acc(0, 12'hFE0 + 12'(4 * i), 0, "R2");
    acc(0, 12'hF00, 0, "R4");
    acc(0, 12'hF04, 0, "R4");
    acc(0, 12'h040, 0, "R5");
    acc(0, 12'h100, 0, "R5");
    acc(0, 12'hFDC, 0, "R5");
    acc(1, 12'hF00, 32'hFFFF_FFFF, "R4");
    acc(1, 12'hF04, 32'hFFFF_FFFF, "R4");
    acc(1, 12'h040, 32'h0000_007F, "R5");
    acc(1, 12'h800, 32'h1234_5678, "R5");
    rdall("R5");
    acc(1, 12'h004, 32'd5, "R10");
    acc(0, 12'h00C, 0, "R10");
    acc(1, 12'h000, 32'h4D, "R1");
    for (int i = 0; i < 20; i++) begin acc(0, 12'h00C, 0, "R7"); idle(1); end
    acc(0, 12'h010, 0, "R7");
    acc(0, 12'h014, 0, "R1");
    acc(1, 12'h018, 0, "R11");
    acc(0, 12'h010, 0, "R11");
    acc(1, 12'h008, 32'd2, "R10");
    for (int i = 0; i < 20; i++) acc(0, 12'h00C, 0, "R8");
    acc(1, 12'h000, 32'h0D, "R3");
    acc(0, 12'h014, 0, "R3");
    acc(0, 12'h010, 0, "R3");
    acc(1, 12'h024, 32'h0001_0003, "R9");
    acc(0, 12'h02C, 0, "R9");
    acc(1, 12'h020, 32'h53, "R6");
    for (int i = 0; i < 70; i++) begin acc(0, 12'h02C, 0, "R6"); idle(1); end
    acc(0, 12'h020, 0, "R8");
    acc(0, 12'h030, 0, "R8");
    acc(1, 12'h038, 0, "R11");
    acc(1, 12'h020, 32'h01, "R8");
    for (int i = 0; i < 10; i++) acc(0, 12'h02C, 0, "R9");
    acc(1, 12'h020, 32'h29, "R6");
    for (int i = 0; i < 60; i++) begin acc(0, 12'h02C, 0, "R6"); idle(8); end
    acc(1, 12'h000, 32'h00, "R1");
    acc(1, 12'h018, 0, "R11");
    rdall("R1");
    idle(2);
    summary();
  end
endmodule